// File: doc/BRIEF.md
# Flash Write-Status Polling Generator

This block stands in for the status-reporting side of a NOR-style flash device while an embedded program or erase algorithm runs. A host issues one command per strobe: a byte program (address and data) or an erase (an explicit sector set, or the whole chip). The block keeps a small byte-wide register file as the cell array. It also keeps a per-sector write-protect map that is sampled when each command is accepted.

Every read returns one of two things. It is either the stored byte, or a status byte whose top bit carries the polling value. The polling value depends on the kind of operation, on whether the read address counts as a valid polling address, and on whether protection blocked the operation. Busy time is counted in clock cycles. When a protected target makes the algorithm a no-op, a fixed window is used instead, derived from a clock-frequency parameter. A busy operation that runs past a timeout count raises a timeout flag in the status byte and freezes the block in status mode until reset. An erase can be suspended, a program can be run inside the suspension, and the erase can then be resumed.

Top module: `flash_poll_status`

## Requirements
- R1: While reset is held, rd_valid and rd_data are 0; after reset every array byte reads 8'hFF.
- R2: A read strobe (rd_en) produces rd_valid exactly one cycle later with the result; when idle, the result is the stored byte at rd_addr.
- R3: A program to an unprotected sector is busy for PROG_CYC cycles after its strobe. Meanwhile a read of the programmed address returns a status byte with bit 7 equal to the inverse of bit 7 of the program data, and all other status bits 0. Afterwards the stored byte becomes old AND data.
- R4: During any busy operation, a read of an address that is not a valid polling address returns a status byte whose bit 7 is the inverse of bit 7 of the stored byte there.
- R5: A program to a protected sector shows program polling status for 2*CLK_MHZ cycles and leaves the array unchanged.
- R6: A sector erase (cmd_kind 2'd2, cmd_sect_sel one bit per sector) reads bit 7 = 0 at any address in a selected sector while busy. It lasts ERASE_CYC cycles per selected unprotected sector, sets only those sectors to 8'hFF, and leaves protected selected sectors intact.
- R7: A chip erase (cmd_kind 2'd3) erases every unprotected sector. Its valid polling addresses are exactly the unprotected sectors.
- R8: An erase whose selection is entirely protected shows erase polling status for 100*CLK_MHZ cycles at any selected address, ignores suspend, and changes no byte.
- R9: suspend_req during a running (unblocked) erase enters suspend at that edge. While suspended, a read in the valid erase area returns 8'h80 and any other read returns array data. Erase time does not advance until resume_req, after which the remaining cycles run.
- R10: A program (cmd_kind 2'd1) issued while suspended reports status exactly as a normal program and returns to the suspended erase when done.
- R11: Commands are accepted only when idle (or a program while suspended); others are ignored. A read in the strobe cycle of a command returns the pre-command view.
- R12: If an unblocked operation is still busy TIMEOUT_CYC cycles after its strobe, status bit 5 becomes 1 and every read returns status until reset; commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Final write strobe of a command |
| cmd_kind | input | 2 | 1 program, 2 sector erase, 3 chip erase |
| cmd_addr | input | ADDR_W | Program address |
| cmd_data | input | 8 | Program data |
| cmd_sect_sel | input | NSECT | Sector selection for sector erase |
| prot_map | input | NSECT | Per-sector write protection |
| suspend_req | input | 1 | Erase suspend request |
| resume_req | input | 1 | Erase resume request |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result (array byte or status) |
| rd_valid | output | 1 | rd_data holds a read result |

## Verification
The bench builds the block with CLK_MHZ=4, PROG_CYC=6, ERASE_CYC=20 and TIMEOUT_CYC=50 on a 64-byte, four-sector array. These values shrink the protected windows to 8 and 400 cycles, so both window edges can be sampled cycle-exactly. A chip erase of four unprotected sectors (80 cycles) overruns the timeout, while one of two sectors (40 cycles) does not, so both sides of the timeout rule are reached in a short run.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_SUSP,
    ST_SPROG,
    ST_TMO
  } fps_state_e;

  localparam logic [1:0] KIND_PROG   = 2'd1;
  localparam logic [1:0] KIND_SERASE = 2'd2;
  localparam logic [1:0] KIND_CERASE = 2'd3;

  localparam logic [7:0] BYTE_ERASED = 8'hFF;

endpackage

// File: rtl/fps_rst_sync.sv
module fps_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic stage_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      hold_q  <= stage_q;
    end
  end

  assign rst_sn = hold_q;

endmodule

// File: rtl/fps_cell_file.sv
module fps_cell_file
  import fps_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned SECT_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pgm_en,
  input  logic [ADDR_W-1:0]     pgm_addr,
  input  logic [7:0]            pgm_data,
  input  logic                  ers_en,
  input  logic [(1<<SECT_W)-1:0] ers_mask,
  input  logic [ADDR_W-1:0]     look_addr,
  output logic [7:0]            look_byte
);

  localparam int unsigned NWORD = 1 << ADDR_W;
  localparam int unsigned OFS_W = ADDR_W - SECT_W;

  logic [7:0] word_vec [NWORD];

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    localparam int unsigned SEC = w >> OFS_W;
    logic       hit_pgm;
    logic       hit_ers;
    logic       we;
    logic [7:0] cell_d;
    logic [7:0] cell_q;

    always_comb begin
      hit_pgm = pgm_en && (pgm_addr == ADDR_W'(w));
      hit_ers = ers_en && ers_mask[SEC];
      we      = hit_pgm || hit_ers;
      cell_d  = hit_ers ? BYTE_ERASED : (cell_q & pgm_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= BYTE_ERASED;
      end else if (we) begin
        cell_q <= cell_d;
      end
    end

    assign word_vec[w] = cell_q;
  end

  assign look_byte = word_vec[look_addr];

endmodule

// File: rtl/fps_op_ctrl.sv
module fps_op_ctrl
  import fps_pkg::*;
#(
  parameter int unsigned ADDR_W         = 6,
  parameter int unsigned SECT_W         = 2,
  parameter int unsigned PROG_CYC       = 700,
  parameter int unsigned ERASE_CYC      = 50000,
  parameter int unsigned PROT_PROG_CYC  = 200,
  parameter int unsigned PROT_ERASE_CYC = 10000,
  parameter int unsigned TIMEOUT_CYC    = 300000,
  parameter int unsigned CNT_W          = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_kind,
  input  logic [ADDR_W-1:0]      cmd_addr,
  input  logic [7:0]             cmd_data,
  input  logic [(1<<SECT_W)-1:0] cmd_sect_sel,
  input  logic [(1<<SECT_W)-1:0] prot_map,
  input  logic                   suspend_req,
  input  logic                   resume_req,
  output fps_state_e             state,
  output logic [ADDR_W-1:0]      prog_addr,
  output logic [7:0]             prog_data,
  output logic [(1<<SECT_W)-1:0] ers_vmask,
  output logic                   tmo_prog,
  output logic                   pgm_en,
  output logic                   ers_en,
  output logic [(1<<SECT_W)-1:0] ers_mask,
  output logic [CNT_W-1:0]       ers_left
);

  localparam int unsigned NSECT = 1 << SECT_W;
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CYC - 1);

  function automatic logic [SECT_W:0] count_set(input logic [NSECT-1:0] v);
    logic [SECT_W:0] n;
    n = '0;
    for (int i = 0; i < NSECT; i++) n = n + (SECT_W+1)'(v[i]);
    return n;
  endfunction

  fps_state_e        st_q, st_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [7:0]        pd_q, pd_d;
  logic              pblk_q, pblk_d;
  logic [CNT_W-1:0]  pleft_q, pleft_d, page_q, page_d;
  logic [NSECT-1:0]  emask_q, emask_d, evm_q, evm_d;
  logic              eblk_q, eblk_d;
  logic [CNT_W-1:0]  eleft_q, eleft_d, eage_q, eage_d;
  logic              tp_q, tp_d;

  // Start values for a new command, computed from the strobe inputs.
  logic              new_pblk;
  logic [CNT_W-1:0]  new_pdur;
  logic [NSECT-1:0]  new_esel, new_emask, new_evm;
  logic              new_eblk;
  logic [CNT_W-1:0]  new_edur;

  always_comb begin
    new_pblk  = prot_map[cmd_addr[ADDR_W-1 -: SECT_W]];
    new_pdur  = new_pblk ? CNT_W'(PROT_PROG_CYC) : CNT_W'(PROG_CYC);
    new_esel  = (cmd_kind == KIND_CERASE) ? '1 : cmd_sect_sel;
    new_emask = new_esel & ~prot_map;
    new_eblk  = (new_emask == '0);
    new_evm   = ((cmd_kind == KIND_CERASE) && !new_eblk) ? ~prot_map : new_esel;
    new_edur  = new_eblk ? CNT_W'(PROT_ERASE_CYC)
                         : CNT_W'(ERASE_CYC) * CNT_W'(count_set(new_emask));
  end

  always_comb begin
    st_d    = st_q;
    pa_d    = pa_q;
    pd_d    = pd_q;
    pblk_d  = pblk_q;
    pleft_d = pleft_q;
    page_d  = page_q;
    emask_d = emask_q;
    evm_d   = evm_q;
    eblk_d  = eblk_q;
    eleft_d = eleft_q;
    eage_d  = eage_q;
    tp_d    = tp_q;
    pgm_en  = 1'b0;
    ers_en  = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid && cmd_kind == KIND_PROG) begin
          st_d    = ST_PROG;
          pa_d    = cmd_addr;
          pd_d    = cmd_data;
          pblk_d  = new_pblk;
          pleft_d = new_pdur;
          page_d  = '0;
        end else if (cmd_valid && cmd_kind != 2'd0) begin
          st_d    = ST_ERASE;
          emask_d = new_emask;
          evm_d   = new_evm;
          eblk_d  = new_eblk;
          eleft_d = new_edur;
          eage_d  = '0;
        end
      end
      ST_PROG, ST_SPROG: begin
        if (pleft_q == CNT_W'(1)) begin
          pgm_en = !pblk_q;
          st_d   = (st_q == ST_PROG) ? ST_IDLE : ST_SUSP;
        end else if (!pblk_q && page_q == TMO_LAST) begin
          st_d = ST_TMO;
          tp_d = 1'b1;
        end else begin
          pleft_d = pleft_q - CNT_W'(1);
          page_d  = page_q + CNT_W'(1);
        end
      end
      ST_ERASE: begin
        if (eleft_q == CNT_W'(1)) begin
          ers_en = !eblk_q;
          st_d   = ST_IDLE;
        end else if (suspend_req && !eblk_q) begin
          st_d = ST_SUSP;
        end else if (!eblk_q && eage_q == TMO_LAST) begin
          st_d = ST_TMO;
          tp_d = 1'b0;
        end else begin
          eleft_d = eleft_q - CNT_W'(1);
          eage_d  = eage_q + CNT_W'(1);
        end
      end
      ST_SUSP: begin
        if (resume_req) begin
          st_d = ST_ERASE;
        end else if (cmd_valid && cmd_kind == KIND_PROG) begin
          st_d    = ST_SPROG;
          pa_d    = cmd_addr;
          pd_d    = cmd_data;
          pblk_d  = new_pblk;
          pleft_d = new_pdur;
          page_d  = '0;
        end
      end
      ST_TMO: st_d = ST_TMO;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pa_q    <= '0;
      pd_q    <= '0;
      pblk_q  <= 1'b0;
      pleft_q <= '0;
      page_q  <= '0;
      emask_q <= '0;
      evm_q   <= '0;
      eblk_q  <= 1'b0;
      eleft_q <= '0;
      eage_q  <= '0;
      tp_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      pa_q    <= pa_d;
      pd_q    <= pd_d;
      pblk_q  <= pblk_d;
      pleft_q <= pleft_d;
      page_q  <= page_d;
      emask_q <= emask_d;
      evm_q   <= evm_d;
      eblk_q  <= eblk_d;
      eleft_q <= eleft_d;
      eage_q  <= eage_d;
      tp_q    <= tp_d;
    end
  end

  assign state     = st_q;
  assign prog_addr = pa_q;
  assign prog_data = pd_q;
  assign ers_vmask = evm_q;
  assign tmo_prog  = tp_q;
  assign ers_mask  = emask_q;
  assign ers_left  = eleft_q;

endmodule

// File: rtl/fps_status_fmt.sv
module fps_status_fmt
  import fps_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned SECT_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  fps_state_e             state,
  input  logic [ADDR_W-1:0]      prog_addr,
  input  logic                   prog_bit7,
  input  logic [(1<<SECT_W)-1:0] ers_vmask,
  input  logic                   tmo_prog,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [7:0]             cell_byte,
  output logic [7:0]             rd_data,
  output logic                   rd_valid
);

  logic       at_prog;
  logic       at_ers;
  logic       poll_prog;
  logic       poll_ers;
  logic [7:0] res_d;

  always_comb begin
    at_prog   = (rd_addr == prog_addr);
    at_ers    = ers_vmask[rd_addr[ADDR_W-1 -: SECT_W]];
    poll_prog = at_prog ? ~prog_bit7 : ~cell_byte[7];
    poll_ers  = at_ers ? 1'b0 : ~cell_byte[7];
    unique case (state)
      ST_IDLE:           res_d = cell_byte;
      ST_PROG, ST_SPROG: res_d = {poll_prog, 7'b0};
      ST_ERASE:          res_d = {poll_ers, 7'b0};
      ST_SUSP:           res_d = at_ers ? 8'h80 : cell_byte;
      ST_TMO:            res_d = {(tmo_prog ? poll_prog : poll_ers), 1'b0, 1'b1, 5'b0};
      default:           res_d = cell_byte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= res_d;
      end
    end
  end

endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import fps_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SECT_W      = 2,
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned PROG_CYC    = 700,
  parameter int unsigned ERASE_CYC   = 50000,
  parameter int unsigned TIMEOUT_CYC = 300000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_kind,
  input  logic [ADDR_W-1:0]      cmd_addr,
  input  logic [7:0]             cmd_data,
  input  logic [(1<<SECT_W)-1:0] cmd_sect_sel,
  input  logic [(1<<SECT_W)-1:0] prot_map,
  input  logic                   suspend_req,
  input  logic                   resume_req,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [7:0]             rd_data,
  output logic                   rd_valid
);

  localparam int unsigned NSECT          = 1 << SECT_W;
  localparam int unsigned PROT_PROG_CYC  = 2 * CLK_MHZ;
  localparam int unsigned PROT_ERASE_CYC = 100 * CLK_MHZ;
  localparam int unsigned FULL_ERASE     = ERASE_CYC * NSECT;
  localparam int unsigned MAX_A = (PROT_ERASE_CYC > FULL_ERASE) ? PROT_ERASE_CYC : FULL_ERASE;
  localparam int unsigned MAX_B = (PROG_CYC > PROT_PROG_CYC) ? PROG_CYC : PROT_PROG_CYC;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_D = (MAX_C > TIMEOUT_CYC) ? MAX_C : TIMEOUT_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_D + 1) + 1;

  logic              rst_sn;
  fps_state_e        st;
  logic [ADDR_W-1:0] pa;
  logic [7:0]        pd;
  logic [NSECT-1:0]  evm;
  logic              tp;
  logic              pgm_en;
  logic              ers_en;
  logic [NSECT-1:0]  emask;
  logic [CNT_W-1:0]  ers_left;
  logic [7:0]        cell_byte;

  fps_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  fps_op_ctrl #(
    .ADDR_W         (ADDR_W),
    .SECT_W         (SECT_W),
    .PROG_CYC       (PROG_CYC),
    .ERASE_CYC      (ERASE_CYC),
    .PROT_PROG_CYC  (PROT_PROG_CYC),
    .PROT_ERASE_CYC (PROT_ERASE_CYC),
    .TIMEOUT_CYC    (TIMEOUT_CYC),
    .CNT_W          (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sn),
    .cmd_valid    (cmd_valid),
    .cmd_kind     (cmd_kind),
    .cmd_addr     (cmd_addr),
    .cmd_data     (cmd_data),
    .cmd_sect_sel (cmd_sect_sel),
    .prot_map     (prot_map),
    .suspend_req  (suspend_req),
    .resume_req   (resume_req),
    .state        (st),
    .prog_addr    (pa),
    .prog_data    (pd),
    .ers_vmask    (evm),
    .tmo_prog     (tp),
    .pgm_en       (pgm_en),
    .ers_en       (ers_en),
    .ers_mask     (emask),
    .ers_left     (ers_left)
  );

  fps_cell_file #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W)
  ) u_cells (
    .clk       (clk),
    .rst_n     (rst_sn),
    .pgm_en    (pgm_en),
    .pgm_addr  (pa),
    .pgm_data  (pd),
    .ers_en    (ers_en),
    .ers_mask  (emask),
    .look_addr (rd_addr),
    .look_byte (cell_byte)
  );

  fps_status_fmt #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W)
  ) u_fmt (
    .clk       (clk),
    .rst_n     (rst_sn),
    .state     (st),
    .prog_addr (pa),
    .prog_bit7 (pd[7]),
    .ers_vmask (evm),
    .tmo_prog  (tp),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .cell_byte (cell_byte),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/fps_checker.sv
module fps_checker
  import fps_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             rd_valid,
  input fps_state_e       state,
  input logic [CNT_W-1:0] ers_left
);

  // R2: one-cycle read turnaround
  a_r2_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R2: no result without a strobe
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R12: timeout holds until reset
  a_r12_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TMO) |=> (state == ST_TMO));

  // R9: erase time frozen while suspended
  a_r9_susp_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP || state == ST_SPROG) |=> $stable(ers_left));

  // R10: a program inside suspend goes back to suspend
  a_r10_sprog_return: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SPROG) |=> (state == ST_SPROG || state == ST_SUSP || state == ST_TMO));

endmodule

bind flash_poll_status fps_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sn),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .state    (st),
  .ers_left (ers_left)
);

// File: tb/sim_flash_poll_status.sv
`timescale 1ns/1ps
module sim_flash_poll_status;

  localparam int unsigned ADDR_W = 6;
  localparam int unsigned SECT_W = 2;
  localparam int unsigned NSECT  = 1 << SECT_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid;
  logic [1:0]        cmd_kind;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data;
  logic [NSECT-1:0]  cmd_sect_sel;
  logic [NSECT-1:0]  prot_map;
  logic              suspend_req;
  logic              resume_req;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              rd_valid;

  always #2 clk = ~clk;

  flash_poll_status #(
    .ADDR_W (ADDR_W), .SECT_W (SECT_W), .CLK_MHZ (4),
    .PROG_CYC (6), .ERASE_CYC (20), .TIMEOUT_CYC (50)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_kind (cmd_kind),
    .cmd_addr (cmd_addr), .cmd_data (cmd_data), .cmd_sect_sel (cmd_sect_sel),
    .prot_map (prot_map), .suspend_req (suspend_req), .resume_req (resume_req),
    .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data), .rd_valid (rd_valid)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0;
  int fails  = 0;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Monitor: pops the scoreboard when a result appears
  always @(negedge clk) begin
    sb_item_t it;
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R2: unexpected result actual %02h expected none", rd_data);
      end else begin
        it = sb_q.pop_front();
        check(it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [7:0] exp, string tag);
    rd_en   = 1'b1;
    rd_addr = a;
    sb_q.push_back('{exp: exp, tag: tag});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic cmd(logic [1:0] kind, logic [ADDR_W-1:0] a, logic [7:0] d,
                     logic [NSECT-1:0] sel);
    cmd_valid    = 1'b1;
    cmd_kind     = kind;
    cmd_addr     = a;
    cmd_data     = d;
    cmd_sect_sel = sel;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_suspend();
    suspend_req = 1'b1;
    @(negedge clk);
    suspend_req = 1'b0;
  endtask

  task automatic pulse_resume();
    resume_req = 1'b1;
    @(negedge clk);
    resume_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = 2'd0; cmd_addr = '0; cmd_data = '0;
    cmd_sect_sel = '0; prot_map = '0; suspend_req = 1'b0; resume_req = 1'b0;
    rd_en = 1'b0; rd_addr = '0;
    tick(3);
    check("R1 reset rd_valid", {7'b0, rd_valid}, 8'h00);
    check("R1 reset rd_data", rd_data, 8'h00);
    rst_n = 1'b1;
    tick(4);
    rd(6'h05, 8'hFF, "R1 erased after reset");
    rd(6'h2A, 8'hFF, "R2 idle array read");

    // Program with a read in the strobe cycle
    rd_en = 1'b1; rd_addr = 6'h05;
    sb_q.push_back('{exp: 8'hFF, tag: "R11 read in strobe cycle"});
    cmd(2'd1, 6'h05, 8'h3C, '0);
    rd_en = 1'b0;
    rd(6'h05, 8'h80, "R3 busy first cycle");
    rd(6'h06, 8'h00, "R4 invalid addr inverse of 1");
    tick(3);
    rd(6'h05, 8'h80, "R3 busy last cycle");
    rd(6'h05, 8'h3C, "R3 programmed byte");

    // Second command while busy is ignored
    cmd(2'd1, 6'h07, 8'h0F, '0);
    cmd(2'd1, 6'h08, 8'h00, '0);
    tick(6);
    rd(6'h07, 8'h0F, "R11 first program done");
    rd(6'h08, 8'hFF, "R11 busy command ignored");

    cmd(2'd1, 6'h25, 8'h12, '0);
    tick(7);
    rd(6'h25, 8'h12, "R3 second program");
    cmd(2'd1, 6'h13, 8'h55, '0);
    rd(6'h25, 8'h80, "R4 invalid addr inverse of 0");
    tick(7);
    rd(6'h13, 8'h55, "R3 third program");
    cmd(2'd1, 6'h05, 8'hF0, '0);
    tick(8);
    rd(6'h05, 8'h30, "R3 program ANDs data");

    // Protected program window
    prot_map = 4'b0010;
    cmd(2'd1, 6'h12, 8'h00, '0);
    rd(6'h12, 8'h80, "R5 protected window start");
    tick(6);
    rd(6'h12, 8'h80, "R5 protected window end");
    rd(6'h12, 8'hFF, "R5 array unchanged");

    // Sector erase with one protected selected sector
    cmd(2'd2, '0, '0, 4'b0011);
    rd(6'h05, 8'h00, "R6 erase busy valid");
    rd(6'h13, 8'h00, "R6 protected selected sector valid");
    rd(6'h25, 8'h80, "R4 erase invalid addr");
    tick(16);
    rd(6'h05, 8'h00, "R6 erase busy last cycle");
    rd(6'h05, 8'hFF, "R6 sector erased");
    rd(6'h07, 8'hFF, "R6 sector erased 2");
    rd(6'h13, 8'h55, "R6 protected sector kept");
    rd(6'h25, 8'h12, "R6 unselected kept");

    // Suspend, program inside suspend, resume
    prot_map = 4'b0000;
    cmd(2'd2, '0, '0, 4'b0100);
    rd(6'h25, 8'h00, "R6 erase busy");
    pulse_suspend();
    rd(6'h25, 8'h80, "R9 suspended status");
    rd(6'h13, 8'h55, "R9 array read in suspend");
    cmd(2'd1, 6'h31, 8'h7F, '0);
    rd(6'h31, 8'h80, "R10 program in suspend status");
    tick(6);
    rd(6'h31, 8'h7F, "R10 program in suspend done");
    rd(6'h25, 8'h80, "R10 back to suspend");
    pulse_resume();
    rd(6'h25, 8'h00, "R9 resumed busy");
    tick(17);
    rd(6'h25, 8'h00, "R9 remaining time last cycle");
    rd(6'h25, 8'hFF, "R9 erase complete");

    // All selected protected: long window, suspend ignored
    prot_map = 4'b1111;
    cmd(2'd3, '0, '0, '0);
    rd(6'h31, 8'h00, "R8 window start");
    pulse_suspend();
    rd(6'h31, 8'h00, "R8 suspend ignored");
    tick(396);
    rd(6'h31, 8'h00, "R8 window end");
    rd(6'h31, 8'h7F, "R8 array unchanged");

    // Chip erase with two protected sectors
    prot_map = 4'b1100;
    cmd(2'd3, '0, '0, '0);
    rd(6'h31, 8'h80, "R7 protected sector invalid");
    rd(6'h13, 8'h00, "R7 unprotected sector valid");
    tick(37);
    rd(6'h13, 8'h00, "R7 busy last cycle");
    rd(6'h13, 8'hFF, "R7 unprotected erased");
    rd(6'h31, 8'h7F, "R7 protected kept");

    // Timeout: four sectors overrun the limit
    prot_map = 4'b0000;
    cmd(2'd3, '0, '0, '0);
    rd(6'h31, 8'h00, "R12 busy before limit");
    tick(48);
    rd(6'h31, 8'h00, "R12 last cycle before limit");
    rd(6'h31, 8'h20, "R12 timeout flag");
    cmd(2'd1, 6'h00, 8'h00, '0);
    tick(47);
    rd(6'h31, 8'h20, "R12 stays after duration");
    rd(6'h00, 8'h20, "R12 command ignored");
    tick(2);
    rst_n = 1'b0;
    tick(2);
    check("R1 reset again rd_valid", {7'b0, rd_valid}, 8'h00);
    rst_n = 1'b1;
    tick(4);
    rd(6'h31, 8'hFF, "R12 cleared by reset");
    rd(6'h00, 8'hFF, "R1 array reset");
    tick(3);
    if (sb_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R2: missing results actual %0d expected 0", sb_q.size());
    end
    summary();
    $finish;
  end

endmodule